// File: doc/BRIEF.md
# Synchronous Burst SRAM Data Path

This block is the storage and data path of a small synchronous SRAM. On every rising clock edge it registers an address, a chip enable, write controls and write data. From these it decides the command for the following cycle: read, write, deselect or sleep. Memory is organised as byte lanes. A write can touch any chosen subset of lanes, or all lanes at once through a global write that overrides the per-lane controls. An external burst sequencer supplies the address on every cycle.

Read data leaves on a dedicated output bus, with a drive flag that stands in for the enable of a tristate bus. A mode input picks, at run time, how read data reaches the pins. With the mode input low, read data goes straight from the array to the pins (flow-through). With it high, read data passes through a rising-edge output register first (pipelined).

Deselect cuts the drive one stage earlier than a pipelined read would deliver its data. An active-low output enable gates the drive without waiting for the clock. A sleep input stops all activity and keeps the memory contents.

The command register is a four-state machine. Its state shows what the registered command is:

- ST_DESEL: chip enable was high at the last edge.
- ST_READ: a read was captured.
- ST_WRITE: a write was captured. The array write is carried out at the next edge.
- ST_SLEEP: sleep was high at the last edge.

Every edge moves the machine to the state of the command just captured, whatever the current state. The order of precedence is: sleep, then chip enable high, then global write, then byte write with at least one lane selected, then read. Reset puts the machine in ST_DESEL.

Top module: `ssram_core`

## Requirements
- R1: While rst_n is low, and after reset until the first read is captured, dout_drive is 0 and dout is all zeros.
- R2: With pipe_mode low, a read captured at edge N drives dout = memory[adr] with dout_drive = 1 in the cycle after edge N. A write captured at edge N leaves dout_drive at 0 in that cycle.
- R3: With pipe_mode high, a read captured at edge N drives its data in the cycle after edge N+1, provided edge N+1 captures a read or a write. In the cycle after edge N, the drive follows only the command captured at edge N-1.
- R4: With gwe_n high and we_byte_n low, each lane i whose lane_sel_n[i] is 0 takes din[i*LANE_W +: LANE_W], and lanes whose select is 1 keep their contents. Lane 0 is the least significant byte.
- R5: we_byte_n low with every lane_sel_n bit at 1 is a read. Any lane_sel_n value with we_byte_n high and gwe_n high is also a read. Neither changes memory.
- R6: gwe_n low with cen_n low writes every lane of din, whatever the values of we_byte_n and lane_sel_n.
- R7: If cen_n is high at edge N, dout_drive is 0 in the cycle after edge N in both modes. In pipelined mode this also suppresses the data of a read captured at edge N-1.
- R8: oe_n high forces dout_drive to 0 at once, without a clock edge. Lowering oe_n restores the drive at once.
- R9: sleep high forces dout_drive to 0 at once. While sleep is high at an edge, nothing is captured and no write is accepted. Memory contents are kept. The first edge after sleep falls captures a command normally.
- R10: A read captured at the edge right after a write to the same address returns the newly written data, in both modes.
- R11: Whenever dout_drive is 0, dout is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 selects the pipelined read path, 0 selects flow-through |
| cen_n | input | 1 | Active-low chip enable, registered |
| adr | input | ADDR_W | Word address from the burst sequencer |
| gwe_n | input | 1 | Active-low global write, writes every lane |
| we_byte_n | input | 1 | Active-low byte-write enable |
| lane_sel_n | input | LANES | Active-low lane selects, bit i selects lane i |
| din | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Active-high low-power input |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_drive | output | 1 | High when dout carries valid driven data |

## Verification
The bench builds the block with ADDR_W = 4, LANES = 2 and LANE_W = 8. This gives 16 words of two lanes, so every address is filled and read back in both read modes. At every address, each of the four lane-select patterns is also applied as a byte write and read back at once against a shadow memory. The bench also covers the orderings that decide the drive: read then deselect, deselect then read, write then read of the same word, and sleep entry and exit around a read.

// File: rtl/ssram_pkg.sv
`timescale 1ns/1ps
package ssram_pkg;
    // Registered command held for the cycle after the capturing edge
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } ssram_state_e;
endpackage

// File: rtl/ssram_cmd_fsm.sv
`timescale 1ns/1ps
module ssram_cmd_fsm
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep,
    input  logic                      cen_n,
    input  logic                      gwe_n,
    input  logic                      we_byte_n,
    input  logic [LANES-1:0]          lane_sel_n,
    input  logic [ADDR_W-1:0]         adr,
    input  logic [LANES*LANE_W-1:0]   din,
    output ssram_state_e              state,
    output logic [ADDR_W-1:0]         addr_q,
    output logic [LANES*LANE_W-1:0]   din_q,
    output logic [LANES-1:0]          lanes_q,
    output logic                      rd_cyc,
    output logic                      wr_cyc,
    output logic                      cut_cyc
);
    localparam int DATA_W = LANES * LANE_W;

    ssram_state_e     nxt_state;
    logic [LANES-1:0] nxt_lanes;
    logic             capture;

    // Command decode: sleep > deselect > global write > byte write > read
    always_comb begin
        nxt_lanes = gwe_n ? ~lane_sel_n : {LANES{1'b1}};
        if (sleep)
            nxt_state = ST_SLEEP;
        else if (cen_n)
            nxt_state = ST_DESEL;
        else if (!gwe_n)
            nxt_state = ST_WRITE;
        else if (!we_byte_n && (lane_sel_n != {LANES{1'b1}}))
            nxt_state = ST_WRITE;
        else
            nxt_state = ST_READ;
        capture = !sleep && !cen_n;
    end

    // State and input register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_DESEL;
            addr_q  <= '0;
            din_q   <= '0;
            lanes_q <= '0;
        end else begin
            state <= nxt_state;
            if (capture) begin
                addr_q  <= adr;
                din_q   <= din[DATA_W-1:0];
                lanes_q <= nxt_lanes;
            end
        end
    end

    // Per-state outputs
    always_comb begin
        rd_cyc  = 1'b0;
        wr_cyc  = 1'b0;
        cut_cyc = 1'b0;
        unique case (state)
            ST_READ:  rd_cyc  = 1'b1;
            ST_WRITE: wr_cyc  = 1'b1;
            ST_DESEL: cut_cyc = 1'b1;
            ST_SLEEP: cut_cyc = 1'b1;
        endcase
    end
endmodule

// File: rtl/ssram_lane_array.sv
`timescale 1ns/1ps
module ssram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          wr_lanes,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    output logic [LANES*LANE_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g])
                cells[addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[addr];
    end
endmodule

// File: rtl/ssram_rd_path.sv
`timescale 1ns/1ps
module ssram_rd_path #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              rd_cyc,
    input  logic              cut_cyc,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drive
);
    logic [DATA_W-1:0] dq_q;
    logic              rvld_q;
    logic              drv_sel;

    // Output register stage for the pipelined path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_q   <= '0;
            rvld_q <= 1'b0;
        end else begin
            rvld_q <= rd_cyc;
            if (rd_cyc)
                dq_q <= rd_data;
        end
    end

    // Drive: deselect cuts the registered read one stage early
    always_comb begin
        drv_sel    = pipe_mode ? (rvld_q && !cut_cyc) : rd_cyc;
        dout_drive = !oe_n && !sleep && drv_sel;
        if (dout_drive)
            dout = pipe_mode ? dq_q : rd_data;
        else
            dout = '0;
    end
endmodule

// File: rtl/ssram_core.sv
`timescale 1ns/1ps
module ssram_core
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pipe_mode,
    input  logic                      cen_n,
    input  logic [ADDR_W-1:0]         adr,
    input  logic                      gwe_n,
    input  logic                      we_byte_n,
    input  logic [LANES-1:0]          lane_sel_n,
    input  logic [LANES*LANE_W-1:0]   din,
    input  logic                      oe_n,
    input  logic                      sleep,
    output logic [LANES*LANE_W-1:0]   dout,
    output logic                      dout_drive
);
    localparam int DATA_W = LANES * LANE_W;

    ssram_state_e      state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic [LANES-1:0]  lanes_q;
    logic              rd_cyc;
    logic              wr_cyc;
    logic              cut_cyc;
    logic [DATA_W-1:0] rd_data;

    ssram_cmd_fsm #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .cen_n      (cen_n),
        .gwe_n      (gwe_n),
        .we_byte_n  (we_byte_n),
        .lane_sel_n (lane_sel_n),
        .adr        (adr),
        .din        (din),
        .state      (state),
        .addr_q     (addr_q),
        .din_q      (din_q),
        .lanes_q    (lanes_q),
        .rd_cyc     (rd_cyc),
        .wr_cyc     (wr_cyc),
        .cut_cyc    (cut_cyc)
    );

    ssram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .wr_en    (wr_cyc),
        .wr_lanes (lanes_q),
        .addr     (addr_q),
        .wr_data  (din_q),
        .rd_data  (rd_data)
    );

    ssram_rd_path #(.DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_mode  (pipe_mode),
        .oe_n       (oe_n),
        .sleep      (sleep),
        .rd_cyc     (rd_cyc),
        .cut_cyc    (cut_cyc),
        .rd_data    (rd_data),
        .dout       (dout),
        .dout_drive (dout_drive)
    );
endmodule

// File: rtl/ssram_core_chk.sv
`timescale 1ns/1ps
module ssram_core_chk (
    input logic clk,
    input logic rst_n,
    input logic cen_n,
    input logic gwe_n,
    input logic we_byte_n,
    input logic lanes_idle,
    input logic sleep,
    input logic oe_n,
    input logic pipe_mode,
    input logic dout_drive,
    input logic dout_zero
);
    logic rd_cmd;
    assign rd_cmd = !cen_n && !sleep && gwe_n && (we_byte_n || lanes_idle);

    // R2
    flow_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> (pipe_mode || oe_n || sleep || dout_drive));

    // R2
    flow_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !sleep && !gwe_n) |=> (pipe_mode || !dout_drive));

    // R3
    pipe_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd ##1 (!cen_n && !sleep) |=> (!pipe_mode || oe_n || sleep || dout_drive));

    // R7
    deselect_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> !dout_drive);

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_drive);

    // R9
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_drive);

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_drive |-> dout_zero);
endmodule

bind ssram_core ssram_core_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cen_n      (cen_n),
    .gwe_n      (gwe_n),
    .we_byte_n  (we_byte_n),
    .lanes_idle (&lane_sel_n),
    .sleep      (sleep),
    .oe_n       (oe_n),
    .pipe_mode  (pipe_mode),
    .dout_drive (dout_drive),
    .dout_zero  (~|dout)
);

// File: tb/test_ssram_core.sv
`timescale 1ns/1ps
module test_ssram_core;
    localparam int AW = 4;
    localparam int NL = 2;
    localparam int LW = 8;
    localparam int DW = NL * LW;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b1;
    logic          cen_n = 1'b1;
    logic [AW-1:0] adr = '0;
    logic          gwe_n = 1'b1;
    logic          we_byte_n = 1'b1;
    logic [NL-1:0] lane_sel_n = '1;
    logic [DW-1:0] din = '0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_drive;

    logic [DW-1:0] shadow [NW];
    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    ssram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_ssram_core (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cen_n(cen_n),
        .adr(adr), .gwe_n(gwe_n), .we_byte_n(we_byte_n),
        .lane_sel_n(lane_sel_n), .din(din), .oe_n(oe_n), .sleep(sleep),
        .dout(dout), .dout_drive(dout_drive)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_read(input int a);
        cen_n = 1'b0; gwe_n = 1'b1; we_byte_n = 1'b1; lane_sel_n = '1;
        adr = a[AW-1:0];
        cyc();
    endtask

    task automatic do_desel();
        cen_n = 1'b1; gwe_n = 1'b1; we_byte_n = 1'b1; lane_sel_n = '1;
        cyc();
    endtask

    // Global write; byte controls set to varying junk to show they are overridden
    task automatic do_gwrite(input int a, input logic [DW-1:0] d);
        cen_n = 1'b0; gwe_n = 1'b0; we_byte_n = a[0]; lane_sel_n = a[2:1];
        adr = a[AW-1:0]; din = d;
        shadow[a] = d;
        cyc();
    endtask

    task automatic do_bwrite(input int a, input logic [NL-1:0] msk_n, input logic [DW-1:0] d);
        cen_n = 1'b0; gwe_n = 1'b1; we_byte_n = 1'b0; lane_sel_n = msk_n;
        adr = a[AW-1:0]; din = d;
        for (int l = 0; l < NL; l++)
            if (!msk_n[l]) shadow[a][l*LW +: LW] = d[l*LW +: LW];
        cyc();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 drive in reset", 32'(dout_drive), 0);
        check("R1 dout in reset", 32'(dout), 0);
        rst_n = 1'b1;
        cyc();
        check("R1 drive after reset", 32'(dout_drive), 0);
        check("R1 dout after reset", 32'(dout), 0);

        // R6: fill every word with global writes, byte controls varying
        pipe_mode = 1'b0;
        for (int a = 0; a < NW; a++) begin
            do_gwrite(a, 16'((a * 16'h1357) ^ 16'hA5C3));
            check("R2 no drive after write", 32'(dout_drive), 0);
        end

        // R2/R6: flow-through sweep, data in cycle after capture
        for (int a = 0; a < NW; a++) begin
            do_read(a);
            check("R2 flow drive", 32'(dout_drive), 1);
            check("R6 flow data", 32'(dout), 32'(shadow[a]));
        end

        // R3: pipelined sweep, first access not driven, then one-edge lag
        pipe_mode = 1'b1;
        do_desel();
        do_read(0);
        check("R3 first access not yet driven", 32'(dout_drive), 0);
        for (int a = 1; a < NW; a++) begin
            do_read(a);
            check("R3 pipe drive", 32'(dout_drive), 1);
            check("R3 pipe data", 32'(dout), 32'(shadow[a-1]));
        end

        // R4/R5/R10: every lane mask at every word, read back at once
        pipe_mode = 1'b0;
        for (int a = 0; a < NW; a++) begin
            for (int m = 0; m < (1 << NL); m++) begin
                do_bwrite(a, NL'(m), 16'((a * 37 + m * 11) ^ 16'h5A5A));
                do_read(a);
                check("R4 R5 R10 lane write", 32'(dout), 32'(shadow[a]));
            end
        end

        // R5: selects asserted with byte enable high is a read
        cen_n = 1'b0; gwe_n = 1'b1; we_byte_n = 1'b1; lane_sel_n = '0;
        adr = 4'd3; din = 16'hDEAD;
        cyc();
        check("R5 enable high read drive", 32'(dout_drive), 1);
        check("R5 enable high no change", 32'(dout), 32'(shadow[3]));
        do_read(3);
        check("R5 word kept", 32'(dout), 32'(shadow[3]));

        // R10: pipelined read right after write
        pipe_mode = 1'b1;
        do_gwrite(9, 16'hC0DE);
        do_read(9);
        do_read(10);
        check("R10 pipe raw", 32'(dout), 32'hC0DE);

        // R7: deselect suppresses pipelined data; deselect-then-read not driven
        do_read(2);
        do_desel();
        check("R7 pipe desel cut", 32'(dout_drive), 0);
        check("R11 dout zero", 32'(dout), 0);
        do_read(4);
        check("R3 after desel not driven", 32'(dout_drive), 0);
        do_read(6);
        check("R3 resumed drive", 32'(dout_drive), 1);
        check("R3 resumed data", 32'(dout), 32'(shadow[4]));
        do_desel();
        check("R7 pipe desel cut 2", 32'(dout_drive), 0);
        pipe_mode = 1'b0;
        do_read(7);
        check("R2 flow before desel", 32'(dout_drive), 1);
        do_desel();
        check("R7 flow desel cut", 32'(dout_drive), 0);

        // R8: asynchronous output enable
        do_read(3);
        check("R8 driven", 32'(dout_drive), 1);
        oe_n = 1'b1;
        #1;
        check("R8 oe off", 32'(dout_drive), 0);
        check("R11 oe off zero", 32'(dout), 0);
        oe_n = 1'b0;
        #1;
        check("R8 oe back", 32'(dout_drive), 1);
        check("R8 oe data", 32'(dout), 32'(shadow[3]));

        // R9: sleep
        do_read(5);
        sleep = 1'b1;
        #1;
        check("R9 sleep cuts drive", 32'(dout_drive), 0);
        cen_n = 1'b0; gwe_n = 1'b0; adr = 4'd5; din = ~shadow[5];
        cyc();
        cyc();
        check("R9 drive off in sleep", 32'(dout_drive), 0);
        sleep = 1'b0;
        cen_n = 1'b0; gwe_n = 1'b1; we_byte_n = 1'b1; lane_sel_n = '1; adr = 4'd5;
        #1;
        check("R9 no drive before edge", 32'(dout_drive), 0);
        cyc();
        check("R9 resume drive", 32'(dout_drive), 1);
        check("R9 contents kept", 32'(dout), 32'(shadow[5]));

        do_desel();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule